// File: doc/BRIEF.md
# Alternate-Line to Alternate-Pixel Interleaver

This block reformats a streaming dual-image video frame. On its input, lines from two images of identical format alternate: the first active line of a frame belongs to the left image, the next to the right image, and so on. In merge mode the block writes each left line into an on-chip line store. When the matching right line arrives, it emits one stored left pixel, then one incoming right pixel, and repeats this to the end of the line. Each output line is therefore twice as long as an input line, and the frame has half as many output lines. A downstream splitter can then separate the two images pixel by pixel.

Both sides use a valid/ready pixel handshake with a start-of-frame marker and an end-of-line marker on 24-bit pixels. Blanking is carried as cycles in which the valid signal is low. Such cycles pass through the block without adding or removing idle time. Because the output needs two transfers for every right-line pixel, the block stalls its input through the ready signal so that no pixel is lost. The mode input is sampled only on the first pixel of each frame. A three-bit status word shows whether merging is active, whether a line has exceeded the store depth, and whether the two lines of a pair had different lengths.

The controller has four states. `ST_PASS` forwards pixels. `ST_FILL` writes the left line into the store. `ST_PAIR_L` emits a stored left pixel. `ST_PAIR_R` accepts and emits the right pixel. The transitions are as follows:
- A start-of-frame pixel moves the controller to `ST_FILL`, or to `ST_PAIR_L` if that pixel also ends its line, when the mode input is high. It moves the controller to `ST_PASS` when the mode input is low.
- `ST_FILL` moves to `ST_PAIR_L` on the end-of-line pixel.
- `ST_PAIR_L` moves to `ST_PAIR_R` after emitting a stored pixel.
- `ST_PAIR_R` returns to `ST_PAIR_L` after a right pixel that does not end the line, and moves to `ST_FILL` after the right pixel that ends the line.

Top module: `vid_line_merge`

## Requirements
- R1: When the mode input is low on a frame's first pixel, every pixel of that frame is output unchanged and in order, with the same start-of-frame and end-of-line markers.
- R2: While out_valid is high and out_ready is low, out_valid and the output data and markers hold their values. Every accepted input pixel appears exactly once on the output.
- R3: In merge mode, a pair of lines of length N gives one output line of 2N pixels: left pixel 0, right pixel 0, left pixel 1, right pixel 1, and so on. The end-of-line marker is set only on the final right pixel. The first line of a pair causes no output.
- R4: The first active line after a start-of-frame pixel is always a left line. A left line still unpaired when a new frame begins is discarded without output.
- R5: Lines of up to MAX_LEN pixels (4095 by default) are merged correctly and raise no status flag.
- R6: Status bit 0 is 1 exactly when the current frame started with the mode input high. Changes of the mode input within a frame take effect only at the next start-of-frame pixel.
- R7: Status bit 1 is set when an active line carries more than MAX_LEN pixels. It stays set until the next accepted start-of-frame pixel clears it.
- R8: Status bit 2 is set when the second line of a pair is shorter or longer than the first. It stays set until the next accepted start-of-frame pixel clears it.
- R9: Cycles with in_valid low, whether between lines or inside a line, produce no output pixel and do not change the line pairing.
- R10: After reset, out_valid is 0, the status word is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_en | input | 1 | Merge-mode select, sampled on each start-of-frame pixel |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can take the input pixel |
| in_data | input | PIX_W | Input pixel |
| in_sof | input | 1 | Input pixel is the first of a frame |
| in_eol | input | 1 | Input pixel is the last of its line |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Sink can take the output pixel |
| out_data | output | PIX_W | Output pixel |
| out_sof | output | 1 | Output pixel is the first of a frame |
| out_eol | output | 1 | Output pixel is the last of its line |
| status | output | 3 | Bit 0 merge active, bit 1 overlong line, bit 2 pair length mismatch |

## Verification
The merge path is driven with:
- full-rate lines, which show the strict left/right interleave and the marker placement;
- random sink backpressure, which separates a correct hold-and-stall from dropped or repeated pixels;
- idle cycles inside and between lines, which show that blanking does not shift the pairing;
- a frame with an odd line count followed by a new frame, which shows that parity restarts at each start of frame;
- a change of the mode input in mid-frame, which shows that the mode is latched only at frame start.

Lines of exactly the store depth are checked against lines one pixel longer, and pairs with a shorter and with a longer second line are checked against equal pairs. Together these separate the overlong and mismatch flags from clean traffic and show that both flags clear at frame start.

// File: rtl/vlm_pkg.sv
package vlm_pkg;

    typedef enum logic [1:0] {
        ST_PASS,
        ST_FILL,
        ST_PAIR_L,
        ST_PAIR_R
    } vlm_state_e;

    localparam int STS_ACTIVE = 0;
    localparam int STS_LONG   = 1;
    localparam int STS_MISM   = 2;
    localparam int STS_W      = 3;
    localparam int FLAG_N     = 2;

endpackage

// File: rtl/vlm_line_store.sv
module vlm_line_store #(
    parameter int W     = 24,
    parameter int DEPTH = 4095,
    parameter int AW    = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

    // R5: writes never fall outside the store
    a_r5_wr_range: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (int'(waddr) < DEPTH));

    // R5: reads never fall outside the store
    a_r5_rd_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(raddr) < DEPTH);

endmodule

// File: rtl/vlm_out_stage.sv
module vlm_out_stage #(
    parameter int W = 26
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_word,
    input  logic         out_ready,
    output logic         out_valid,
    output logic [W-1:0] out_word
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            if (ld) begin
                out_valid <= 1'b1;
                out_word  <= ld_word;
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end
        end
    end

    // R2: the controller never loads over a pixel the sink has not taken
    a_r2_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        ld |-> (!out_valid || out_ready));

endmodule

// File: rtl/vlm_status.sv
module vlm_status #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [N-1:0] set,
    output logic [N-1:0] flags
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= (clr ? '0 : flags) | set;
        end
    end

    // R7/R8: a flag that is up stays up until a frame start clears it
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((flags & $past(flags)) == $past(flags)));

    // R7: a frame start with no new event leaves all flags clear
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && (set == '0)) |=> (flags == '0));

endmodule

// File: rtl/vlm_ctrl.sv
module vlm_ctrl
    import vlm_pkg::*;
#(
    parameter int MAX_LEN = 4095,
    parameter int CNT_W   = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_en,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_eol,
    input  logic             out_free,
    output logic             in_ready,
    output logic             ld,
    output logic             ld_sel_buf,
    output logic             ld_sof,
    output logic             ld_eol,
    output logic             we,
    output logic [CNT_W-1:0] waddr,
    output logic [CNT_W-1:0] raddr,
    output logic             ev_long,
    output logic             ev_mism,
    output logic             clr_flags,
    output logic             active
);

    localparam logic [CNT_W-1:0] MAX_C  = CNT_W'(MAX_LEN);
    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(MAX_LEN - 1);

    vlm_state_e state, nstate;

    logic [CNT_W-1:0] wr_cnt;
    logic [CNT_W-1:0] rd_cnt;
    logic [CNT_W-1:0] len1;
    logic             pair_sof;

    logic             buf_acc;
    logic             pr_acc;
    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] base_nx;
    logic [CNT_W:0]   rd_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_PASS;
        end else begin
            state <= nstate;
        end
    end

    // next state and handshake outputs
    always_comb begin
        nstate     = state;
        in_ready   = 1'b0;
        ld         = 1'b0;
        ld_sel_buf = 1'b0;
        ld_sof     = 1'b0;
        ld_eol     = 1'b0;
        buf_acc    = 1'b0;
        pr_acc     = 1'b0;
        if (in_sof) begin
            if (mode_en) begin
                in_ready = 1'b1;
                buf_acc  = in_valid;
                if (in_valid) begin
                    nstate = in_eol ? ST_PAIR_L : ST_FILL;
                end
            end else begin
                in_ready = out_free;
                ld       = in_valid && out_free;
                ld_sof   = 1'b1;
                ld_eol   = in_eol;
                if (ld) begin
                    nstate = ST_PASS;
                end
            end
        end else begin
            unique case (state)
                ST_PASS: begin
                    in_ready = out_free;
                    ld       = in_valid && out_free;
                    ld_eol   = in_eol;
                end
                ST_FILL: begin
                    in_ready = 1'b1;
                    buf_acc  = in_valid;
                    if (in_valid && in_eol) begin
                        nstate = ST_PAIR_L;
                    end
                end
                ST_PAIR_L: begin
                    ld         = in_valid && out_free;
                    ld_sel_buf = 1'b1;
                    ld_sof     = pair_sof;
                    if (ld) begin
                        nstate = ST_PAIR_R;
                    end
                end
                ST_PAIR_R: begin
                    in_ready = out_free;
                    pr_acc   = in_valid && out_free;
                    ld       = pr_acc;
                    ld_eol   = in_eol;
                    if (pr_acc) begin
                        nstate = in_eol ? ST_FILL : ST_PAIR_L;
                    end
                end
                default: nstate = ST_PASS;
            endcase
        end
    end

    // counters, store addressing and status events
    always_comb begin
        base      = in_sof ? '0 : wr_cnt;
        base_nx   = (base == MAX_C) ? MAX_C : base + CNT_W'(1);
        we        = buf_acc && (base != MAX_C);
        waddr     = base;
        rd_nx     = {1'b0, rd_cnt} + (CNT_W+1)'(1);
        raddr     = (rd_cnt == MAX_C) ? LAST_C : rd_cnt;
        ev_long   = (buf_acc && (base == MAX_C)) || (pr_acc && (rd_cnt == MAX_C));
        ev_mism   = pr_acc && (in_eol ? (rd_nx != {1'b0, len1})
                                      : (rd_nx >= {1'b0, len1}));
        clr_flags = in_valid && in_ready && in_sof;
        active    = (state != ST_PASS);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_cnt   <= '0;
            rd_cnt   <= '0;
            len1     <= '0;
            pair_sof <= 1'b0;
        end else begin
            if (buf_acc) begin
                if (in_eol) begin
                    len1   <= base_nx;
                    wr_cnt <= '0;
                    rd_cnt <= '0;
                end else begin
                    wr_cnt <= base_nx;
                end
            end
            if (pr_acc) begin
                if (in_eol) begin
                    rd_cnt <= '0;
                end else if (rd_cnt != MAX_C) begin
                    rd_cnt <= rd_nx[CNT_W-1:0];
                end
            end
            if (buf_acc && in_sof) begin
                pair_sof <= 1'b1;
            end else if (clr_flags) begin
                pair_sof <= 1'b0;
            end else if (ld && ld_sel_buf) begin
                pair_sof <= 1'b0;
            end
        end
    end

    // R3: a right pixel is only taken directly after a stored left pixel
    a_r3_pair_order: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAIR_R) |-> ($past(state) == ST_PAIR_L || $past(state) == ST_PAIR_R));

    // R3: pairing only starts once a left line of at least one pixel is stored
    a_r3_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAIR_L) |-> (len1 != '0));

    // R4: a start-of-frame pixel in merge mode never produces output by itself
    a_r4_sof_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof && mode_en) |-> !ld);

endmodule

// File: rtl/vid_line_merge.sv
module vid_line_merge
    import vlm_pkg::*;
#(
    parameter int PIX_W   = 24,
    parameter int MAX_LEN = 4095
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_en,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [PIX_W-1:0] in_data,
    input  logic             in_sof,
    input  logic             in_eol,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [PIX_W-1:0] out_data,
    output logic             out_sof,
    output logic             out_eol,
    output logic [2:0]       status
);

    localparam int CNT_W  = $clog2(MAX_LEN + 1);
    localparam int WORD_W = PIX_W + 2;

    logic             out_free;
    logic             ld, ld_sel_buf, ld_sof, ld_eol;
    logic             we;
    logic [CNT_W-1:0] waddr, raddr;
    logic [PIX_W-1:0] rdata;
    logic             ev_long, ev_mism, clr_flags, active;
    logic [FLAG_N-1:0] flags;
    logic [WORD_W-1:0] ld_word, out_word;

    assign out_free = !out_valid || out_ready;

    vlm_ctrl #(
        .MAX_LEN (MAX_LEN),
        .CNT_W   (CNT_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_en    (mode_en),
        .in_valid   (in_valid),
        .in_sof     (in_sof),
        .in_eol     (in_eol),
        .out_free   (out_free),
        .in_ready   (in_ready),
        .ld         (ld),
        .ld_sel_buf (ld_sel_buf),
        .ld_sof     (ld_sof),
        .ld_eol     (ld_eol),
        .we         (we),
        .waddr      (waddr),
        .raddr      (raddr),
        .ev_long    (ev_long),
        .ev_mism    (ev_mism),
        .clr_flags  (clr_flags),
        .active     (active)
    );

    vlm_line_store #(
        .W     (PIX_W),
        .DEPTH (MAX_LEN),
        .AW    (CNT_W)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we),
        .waddr (waddr),
        .wdata (in_data),
        .raddr (raddr),
        .rdata (rdata)
    );

    assign ld_word = {ld_sof, ld_eol, (ld_sel_buf ? rdata : in_data)};

    vlm_out_stage #(
        .W (WORD_W)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld        (ld),
        .ld_word   (ld_word),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_word  (out_word)
    );

    vlm_status #(
        .N (FLAG_N)
    ) u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_flags),
        .set   ({ev_mism, ev_long}),
        .flags (flags)
    );

    assign out_sof  = out_word[WORD_W-1];
    assign out_eol  = out_word[WORD_W-2];
    assign out_data = out_word[PIX_W-1:0];

    always_comb begin
        status             = '0;
        status[STS_ACTIVE] = active;
        status[STS_LONG]   = flags[0];
        status[STS_MISM]   = flags[1];
    end

    // R2: a stalled output pixel holds still
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                       && $stable(out_sof) && $stable(out_eol)));

endmodule

// File: tb/vid_line_merge_tb.sv
module vid_line_merge_tb;

    localparam int PIX_W   = 24;
    localparam int MAX_LEN = 8;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             mode_en;
    logic             in_valid;
    logic             in_ready;
    logic [PIX_W-1:0] in_data;
    logic             in_sof;
    logic             in_eol;
    logic             out_valid;
    logic             out_ready;
    logic [PIX_W-1:0] out_data;
    logic             out_sof;
    logic             out_eol;
    logic [2:0]       status;

    always #4 clk = ~clk;

    vid_line_merge #(
        .PIX_W   (PIX_W),
        .MAX_LEN (MAX_LEN)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_en   (mode_en),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .in_sof    (in_sof),
        .in_eol    (in_eol),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_sof   (out_sof),
        .out_eol   (out_eol),
        .status    (status)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit bp_on  = 1'b0;
    bit sb_on  = 1'b1;
    logic [15:0] lfsr = 16'hACE1;
    logic [PIX_W+1:0] exp_q [$];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [PIX_W-1:0] pix(input int fr, input int ln, input int p);
        return {8'(fr), 8'(ln), 8'(p)};
    endfunction

    // sink backpressure, changed shortly after each rising edge
    initial begin
        out_ready = 1'b1;
        forever begin
            @(posedge clk);
            #2;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            out_ready = bp_on ? (lfsr[0] | lfsr[5]) : 1'b1;
        end
    end

    // monitor: pops the scoreboard for every output transfer
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n === 1'b1 && out_valid && out_ready && sb_on) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected output", 32'({out_sof, out_eol, out_data}), 32'h0);
                end else begin
                    logic [PIX_W+1:0] e;
                    e = exp_q.pop_front();
                    chk({out_sof, out_eol, out_data} == e, "R1/R2/R3 output pixel",
                        32'({out_sof, out_eol, out_data}), 32'(e));
                end
            end
        end
    end

    task automatic send(input logic [PIX_W-1:0] d, input bit sof, input bit eol);
        bit hs;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        in_sof   = sof;
        in_eol   = eol;
        forever begin
            #1;
            hs = in_ready;
            @(posedge clk);
            if (hs) break;
            @(negedge clk);
        end
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        in_sof   = 1'b0;
        in_eol   = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // R9: gap > 0 inserts idle cycles between pixels of the line
    task automatic send_line(input int fr, input int ln, input int len, input bit sof, input int gap);
        for (int p = 0; p < len; p++) begin
            send(pix(fr, ln, p), sof && (p == 0), p == len - 1);
            if (gap > 0 && p != len - 1) idle(gap);
        end
    endtask

    task automatic push_pass(input int fr, input int ln, input int len, input bit sof);
        for (int p = 0; p < len; p++) begin
            exp_q.push_back({sof && (p == 0), p == len - 1, pix(fr, ln, p)});
        end
    endtask

    task automatic push_pair(input int fr, input int ln, input int len, input bit sof);
        for (int p = 0; p < len; p++) begin
            exp_q.push_back({sof && (p == 0), 1'b0, pix(fr, ln, p)});
            exp_q.push_back({1'b0, p == len - 1, pix(fr, ln + 1, p)});
        end
    endtask

    task automatic drain;
        idle(1);
        while (exp_q.size() != 0) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired, run did not complete");
        summary();
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        mode_en  = 1'b0;
        in_valid = 1'b0;
        in_data  = '0;
        in_sof   = 1'b0;
        in_eol   = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        chk(out_valid == 1'b0, "R10 out_valid after reset", 32'(out_valid), 32'h0);
        chk(status == 3'b000, "R10 status after reset", 32'(status), 32'h0);
        chk(in_ready == 1'b1, "R10 in_ready after reset", 32'(in_ready), 32'h1);

        // R1: pass-through frame
        mode_en = 1'b0;
        push_pass(1, 0, 5, 1'b1);
        push_pass(1, 1, 5, 1'b0);
        send_line(1, 0, 5, 1'b1, 0);
        send_line(1, 1, 5, 1'b0, 0);
        drain();
        chk(status[0] == 1'b0, "R1 status active in pass mode", 32'(status), 32'h0);

        // R3: merged frame at full rate
        mode_en = 1'b1;
        push_pair(2, 0, 6, 1'b1);
        push_pair(2, 2, 6, 1'b0);
        send_line(2, 0, 6, 1'b1, 0);
        chk(status[0] == 1'b1, "R6 status active after merge frame start", 32'(status), 32'h1);
        send_line(2, 1, 6, 1'b0, 0);
        send_line(2, 2, 6, 1'b0, 0);
        send_line(2, 3, 6, 1'b0, 0);
        drain();

        // R2: merged frame under random backpressure
        bp_on = 1'b1;
        push_pair(3, 0, 5, 1'b1);
        push_pair(3, 2, 5, 1'b0);
        for (int l = 0; l < 4; l++) send_line(3, l, 5, l == 0, 0);
        drain();

        // R9: idle cycles inside and between lines
        push_pair(4, 0, 4, 1'b1);
        push_pair(4, 2, 4, 1'b0);
        for (int l = 0; l < 4; l++) begin
            send_line(4, l, 4, l == 0, 2);
            idle(5);
        end
        drain();
        chk(exp_q.size() == 0, "R9 all pixels delivered with gaps", 32'(exp_q.size()), 32'h0);

        // R5: lines of exactly MAX_LEN pixels
        push_pair(5, 0, MAX_LEN, 1'b1);
        send_line(5, 0, MAX_LEN, 1'b1, 0);
        send_line(5, 1, MAX_LEN, 1'b0, 0);
        drain();
        chk(status == 3'b001, "R5 no flag for full-length lines", 32'(status), 32'h1);

        // R4: odd line count, the trailing left line is dropped
        push_pair(6, 0, 3, 1'b1);
        for (int l = 0; l < 3; l++) send_line(6, l, 3, l == 0, 0);
        push_pair(7, 0, 4, 1'b1);
        send_line(7, 0, 4, 1'b1, 0);
        send_line(7, 1, 4, 1'b0, 0);
        drain();
        chk(exp_q.size() == 0, "R4 parity restarts at frame start", 32'(exp_q.size()), 32'h0);

        // R6: mode change mid-frame is ignored
        bp_on = 1'b0;
        push_pair(8, 0, 3, 1'b1);
        push_pair(8, 2, 3, 1'b0);
        send_line(8, 0, 3, 1'b1, 0);
        mode_en = 1'b0;
        for (int l = 1; l < 4; l++) send_line(8, l, 3, 1'b0, 0);
        drain();
        chk(status[0] == 1'b1, "R6 mode held within frame", 32'(status), 32'h1);
        push_pass(9, 0, 3, 1'b1);
        send_line(9, 0, 3, 1'b1, 0);
        drain();
        chk(status[0] == 1'b0, "R6 mode taken at next frame start", 32'(status), 32'h0);

        // R7: overlong line raises the flag, next frame start clears it
        sb_on   = 1'b0;
        mode_en = 1'b1;
        send_line(10, 0, MAX_LEN + 1, 1'b1, 0);
        idle(3);
        chk(status[1] == 1'b1, "R7 overlong flag set", 32'(status), 32'h3);
        send_line(10, 1, 2, 1'b0, 0);
        idle(3);
        chk(status[1] == 1'b1, "R7 overlong flag sticky", 32'(status), 32'h3);
        send_line(11, 0, 3, 1'b1, 0);
        idle(3);
        chk(status[1] == 1'b0, "R7 overlong flag cleared at frame start", 32'(status), 32'h1);
        send_line(11, 1, 3, 1'b0, 0);
        idle(10);

        // R8: shorter second line
        send_line(12, 0, 4, 1'b1, 0);
        send_line(12, 1, 3, 1'b0, 0);
        idle(10);
        chk(status[2] == 1'b1, "R8 mismatch flag on short second line", 32'(status), 32'h5);
        // R8: longer second line, after the frame start clears the flag
        send_line(13, 0, 3, 1'b1, 0);
        idle(3);
        chk(status[2] == 1'b0, "R8 mismatch flag cleared at frame start", 32'(status), 32'h1);
        send_line(13, 1, 4, 1'b0, 0);
        idle(10);
        chk(status[2] == 1'b1, "R8 mismatch flag on long second line", 32'(status), 32'h5);
        idle(10);
        sb_on = 1'b1;

        // R8: a clean frame afterwards merges correctly with no flags
        push_pair(14, 0, 2, 1'b1);
        send_line(14, 0, 2, 1'b1, 0);
        send_line(14, 1, 2, 1'b0, 0);
        drain();
        chk(status == 3'b001, "R8 clean frame after errors", 32'(status), 32'h1);

        summary();
        $finish;
    end

endmodule